// File: doc/BRIEF.md
# PTP Ingress Timestamp Inserter

This block sits in a byte-wide receive path and overwrites chosen header bytes of qualifying PTP event messages with the ingress time of the frame. An upstream parser marks the first byte of the PTP header. A timestamp unit supplies the ingress time, already corrected for latency, as seconds and nanoseconds. The block then patches the passing stream. It writes a 32-bit nanoseconds word at one programmable header offset. It can also write a small seconds byte at a second programmable offset. Every other byte passes through untouched behind a single register stage.

A frame qualifies when two tests pass. Its message type must be enabled in a 16-bit per-type mask, and its version nibble must match the configured version; a configured version of zero accepts any version. The domain and the flag bytes take no part in the decision. The block has its own insertion enables. Any capture of the same timestamp into registers elsewhere goes on whether or not a frame is patched. A side output marks the final beat of every frame in which at least one byte was replaced.

Both stream sides use valid/ready. A beat moves when valid and ready are both high in the same cycle. The input accepts a beat whenever the output register is empty or is being drained in the same cycle. While out_ready is low, the output beat is held unchanged and in_ready stays low, so no data is lost or reordered under back-pressure.

Top module: `ptpi_inserter`

## Requirements
- R1: Each accepted input beat appears exactly once on the output, in order, one register stage later, with in_last carried along. in_ready is high exactly when the output register is empty or out_ready is high. While out_valid is high and out_ready low, out_data, out_last and out_stamped hold.
- R2: The beat with in_hdr_start high is header position 0. Each further accepted beat advances the position by one until the beat carrying in_last. Bytes before the marker are never modified. Offsets are counted in header positions.
- R3: The message type is bits 3:0 of header position 0. A frame is modified only if cfg_type_mask[type] is 1. Bits 7:4 of that byte are ignored.
- R4: The version is bits 3:0 of header position 1. A frame is modified only if it equals cfg_version, or if cfg_version is 0.
- R5: With cfg_ins_en high, header positions N to N+3 (N = cfg_ns_offset) carry the word {ts_sec[1:0], ts_ns[29:0]}, most significant byte at N. Bits 31:30 of ts_ns are discarded.
- R6: With cfg_ins_en and cfg_sec_en both high, header position cfg_sec_offset carries {4'b0000, ts_sec[3:0]}. cfg_sec_en alone modifies nothing, and cfg_ins_en low modifies nothing.
- R7: When the seconds position falls inside the four nanoseconds positions, the nanoseconds byte is written there.
- R8: An offset below 2 disables that field; no byte is written for it.
- R9: The timestamp used for a frame is the ts_sec/ts_ns value present on the header-start beat. Later changes to ts_sec or ts_ns do not affect that frame.
- R10: out_stamped is high only on the output beat that carries out_last, and only if at least one byte of that frame was replaced. A frame that ends before its offsets are reached is not stamped.
- R11: Bytes of non-qualifying frames, and bytes at positions other than the selected ones, pass unchanged. This includes the domain and flag bytes of the header.
- R12: During and right after reset, out_valid and out_stamped are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the frame |
| in_hdr_start | input | 1 | This byte is header position 0 |
| ts_sec | input | SEC_W | Ingress time, seconds |
| ts_ns | input | NS_W | Ingress time, nanoseconds |
| cfg_ins_en | input | 1 | Enable nanoseconds insertion (master enable) |
| cfg_sec_en | input | 1 | Enable seconds-byte insertion |
| cfg_type_mask | input | 16 | Per-message-type enable mask |
| cfg_version | input | 4 | Required version, 0 = any |
| cfg_ns_offset | input | OFF_W | Header position of the nanoseconds word |
| cfg_sec_offset | input | OFF_W | Header position of the seconds byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Output byte, possibly replaced |
| out_last | output | 1 | Final byte of the frame |
| out_stamped | output | 1 | Final beat of a frame that was modified |

## Verification
Two cases can fall in the same cycle. In the first, the seconds byte and one nanoseconds byte claim the same header position. The bench provokes this by placing the seconds offset inside the nanoseconds window and expects the nanoseconds byte at that position. In the second, a replaced byte and the stamp marker land on one output beat while back-pressure is active. Frames are sized so that the last nanoseconds byte is the final byte, and a pseudo-random out_ready pattern stalls the output. The scoreboard must then see that beat once, carrying the patched data, out_last and out_stamped all together.

// File: rtl/ptpi_pkg.sv
package ptpi_pkg;
  localparam int BYTE_W    = 8;
  localparam int NIB_W     = 4;
  localparam int NS_BYTES  = 4;
  localparam int MSG_TYPES = 1 << NIB_W;
  localparam int MIN_OFF   = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;
endpackage

// File: rtl/ptpi_hdr_track.sv
module ptpi_hdr_track
  import ptpi_pkg::*;
#(
  parameter int OFF_W = 6,
  parameter int POS_W = OFF_W + 1,
  parameter int SEC_W = 32,
  parameter int NS_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat,
  input  logic                 hdr_start,
  input  logic                 last,
  input  byte_t                data,
  input  logic [SEC_W-1:0]     ts_sec,
  input  logic [NS_W-1:0]      ts_ns,
  input  logic [MSG_TYPES-1:0] type_mask,
  input  nib_t                 version,
  output logic                 in_hdr_now,
  output logic [POS_W-1:0]     pos_now,
  output logic                 qual_now,
  output logic [SEC_W-1:0]     sec_q,
  output logic [NS_W-1:0]      ns_q
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             in_hdr_q;
  logic [POS_W-1:0] pos_q;
  logic             type_ok_q;
  logic             ver_ok_q;

  assign in_hdr_now = hdr_start | in_hdr_q;
  assign pos_now    = hdr_start ? '0 : pos_q;
  assign qual_now   = type_ok_q & ver_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_hdr_q  <= 1'b0;
      pos_q     <= '0;
      type_ok_q <= 1'b0;
      ver_ok_q  <= 1'b0;
      sec_q     <= '0;
      ns_q      <= '0;
    end else if (beat) begin
      if (hdr_start) begin
        sec_q <= ts_sec;
        ns_q  <= ts_ns;
      end
      if (in_hdr_now && pos_now == POS_W'(0))
        type_ok_q <= type_mask[data[NIB_W-1:0]];
      if (in_hdr_now && pos_now == POS_W'(1))
        ver_ok_q <= (version == '0) || (data[NIB_W-1:0] == version);
      in_hdr_q <= in_hdr_now & ~last;
      if (in_hdr_now)
        pos_q <= (pos_now == POS_MAX) ? pos_now : pos_now + POS_W'(1);
    end
  end
endmodule

// File: rtl/ptpi_byte_patch.sv
module ptpi_byte_patch
  import ptpi_pkg::*;
#(
  parameter int OFF_W = 6,
  parameter int POS_W = OFF_W + 1,
  parameter int NS_W  = 32
) (
  input  logic             in_hdr,
  input  logic [POS_W-1:0] pos,
  input  logic             qual,
  input  logic             ins_en,
  input  logic             sec_en,
  input  logic [OFF_W-1:0] ns_off,
  input  logic [OFF_W-1:0] sec_off,
  input  nib_t             sec_lo,
  input  logic [NS_W-1:0]  ns_val,
  input  byte_t            data_in,
  output byte_t            data_out,
  output logic             hit
);
  localparam int SEL_W = $clog2(NS_BYTES);

  logic [NS_W-1:0]  word;
  byte_t            ns_byte [NS_BYTES];
  logic [POS_W-1:0] ns_base;
  logic [POS_W-1:0] ns_rel;
  logic             allow;
  logic             ns_hit;
  logic             sec_hit;

  assign word = {sec_lo[1:0], ns_val[NS_W-3:0]};

  for (genvar g = 0; g < NS_BYTES; g++) begin : g_ns_byte
    assign ns_byte[g] = word[(NS_BYTES-g)*BYTE_W-1 -: BYTE_W];
  end

  assign ns_base = POS_W'(ns_off);
  assign ns_rel  = pos - ns_base;
  assign allow   = in_hdr & qual & ins_en;
  assign ns_hit  = allow && (ns_off >= OFF_W'(MIN_OFF)) && (pos >= ns_base)
                   && (ns_rel < POS_W'(NS_BYTES));
  assign sec_hit = allow && sec_en && (sec_off >= OFF_W'(MIN_OFF))
                   && (pos == POS_W'(sec_off));

  always_comb begin
    data_out = data_in;
    if (ns_hit)
      data_out = ns_byte[ns_rel[SEL_W-1:0]];
    else if (sec_hit)
      data_out = {{(BYTE_W-NIB_W){1'b0}}, sec_lo};
  end

  assign hit = ns_hit | sec_hit;
endmodule

// File: rtl/ptpi_inserter.sv
module ptpi_inserter
  import ptpi_pkg::*;
#(
  parameter int OFF_W = 6,
  parameter int SEC_W = 32,
  parameter int NS_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  input  logic                 in_last,
  input  logic                 in_hdr_start,
  input  logic [SEC_W-1:0]     ts_sec,
  input  logic [NS_W-1:0]      ts_ns,
  input  logic                 cfg_ins_en,
  input  logic                 cfg_sec_en,
  input  logic [15:0]          cfg_type_mask,
  input  logic [3:0]           cfg_version,
  input  logic [OFF_W-1:0]     cfg_ns_offset,
  input  logic [OFF_W-1:0]     cfg_sec_offset,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic                 out_last,
  output logic                 out_stamped
);
  localparam int POS_W = OFF_W + 1;

  logic             beat;
  logic             in_hdr_now;
  logic [POS_W-1:0] pos_now;
  logic             qual_now;
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;
  byte_t            patched;
  logic             hit;
  logic             mod_q;
  logic             mod_sofar;

  assign in_ready = ~out_valid | out_ready;
  assign beat     = in_valid & in_ready;

  ptpi_hdr_track #(.OFF_W(OFF_W), .POS_W(POS_W), .SEC_W(SEC_W), .NS_W(NS_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .hdr_start (in_hdr_start),
    .last      (in_last),
    .data      (in_data),
    .ts_sec    (ts_sec),
    .ts_ns     (ts_ns),
    .type_mask (cfg_type_mask),
    .version   (cfg_version),
    .in_hdr_now(in_hdr_now),
    .pos_now   (pos_now),
    .qual_now  (qual_now),
    .sec_q     (sec_q),
    .ns_q      (ns_q)
  );

  ptpi_byte_patch #(.OFF_W(OFF_W), .POS_W(POS_W), .NS_W(NS_W)) u_patch (
    .in_hdr  (in_hdr_now),
    .pos     (pos_now),
    .qual    (qual_now),
    .ins_en  (cfg_ins_en),
    .sec_en  (cfg_sec_en),
    .ns_off  (cfg_ns_offset),
    .sec_off (cfg_sec_offset),
    .sec_lo  (sec_q[NIB_W-1:0]),
    .ns_val  (ns_q),
    .data_in (in_data),
    .data_out(patched),
    .hit     (hit)
  );

  assign mod_sofar = (mod_q & ~in_hdr_start) | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_last    <= 1'b0;
      out_stamped <= 1'b0;
      mod_q       <= 1'b0;
    end else if (beat) begin
      out_valid   <= 1'b1;
      out_data    <= patched;
      out_last    <= in_last;
      out_stamped <= in_last & mod_sofar;
      mod_q       <= mod_sofar & ~in_last;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      out_stamped <= 1'b0;
    end
  end
endmodule

// File: rtl/ptpi_inserter_chk.sv
module ptpi_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       cfg_ins_en,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_stamped
);
  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
                                && $stable(out_stamped));

  a_r1_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r1_beat_lands: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r6_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_ins_en |=> out_data == $past(in_data));

  a_r10_stamp_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stamped |-> out_last);
endmodule

bind ptpi_inserter ptpi_inserter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .cfg_ins_en (cfg_ins_en),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .out_stamped(out_stamped)
);

// File: tb/ptpi_inserter_tb.sv
module ptpi_inserter_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] data;
    logic       last;
    logic       stamped;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_hdr_start = 1'b0;
  logic [31:0] ts_sec = '0;
  logic [31:0] ts_ns = '0;
  logic        cfg_ins_en = 1'b0;
  logic        cfg_sec_en = 1'b0;
  logic [15:0] cfg_type_mask = '0;
  logic [3:0]  cfg_version = '0;
  logic [5:0]  cfg_ns_offset = '0;
  logic [5:0]  cfg_sec_offset = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_stamped;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 1'b0;
  bit   stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t q[$];

  ptpi_inserter u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic lfsr_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // downstream ready pattern, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      out_ready = stall_en ? (lfsr_bit() | lfsr[3]) : 1'b1;
    end
  end

  // monitor: a beat is consumed at the next edge when valid and ready
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check("R1", {24'd0, out_data}, 32'hFFFF_FFFF, "unexpected beat");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, {24'd0, out_data}, {24'd0, e.data}, "data");
          check("R1", {31'd0, out_last}, {31'd0, e.last}, "last");
          check("R10", {31'd0, out_stamped}, {31'd0, e.stamped}, "stamped");
        end
      end
      if (rst_n && out_valid && !out_ready)
        check("R1", {31'd0, in_ready}, 32'd0, "in_ready under stall");
    end
  end

  function automatic logic [7:0] frame_byte(int i, int pre, logic [3:0] mt, logic [3:0] mv);
    if (i < pre) return 8'h40 + 8'(i);
    if (i == pre) return {4'hC, mt};
    if (i == pre + 1) return {4'h3, mv};
    return 8'h80 ^ 8'((i - pre) * 7);
  endfunction

  task automatic send_frame(input string tag, input int pre, input int hlen,
                            input logic [3:0] mt, input logic [3:0] mv,
                            input logic [31:0] sec, input logic [31:0] ns,
                            input bit scramble_ts);
    int total = pre + hlen;
    bit qual = cfg_type_mask[mt] && (cfg_version == 4'd0 || mv == cfg_version);
    bit any = 1'b0;
    logic [31:0] word = {sec[1:0], ns[29:0]};
    for (int i = 0; i < total; i++) begin
      exp_t e;
      int p = i - pre;
      e.data = frame_byte(i, pre, mt, mv);
      e.tag  = tag;
      if (p >= 0 && cfg_ins_en && qual) begin
        if (cfg_ns_offset >= 2 && p >= int'(cfg_ns_offset) && p < int'(cfg_ns_offset) + 4) begin
          e.data = word[8*(4-(p-int'(cfg_ns_offset)))-1 -: 8];
          any = 1'b1;
        end else if (cfg_sec_en && cfg_sec_offset >= 2 && p == int'(cfg_sec_offset)) begin
          e.data = {4'h0, sec[3:0]};
          any = 1'b1;
        end
      end
      e.last    = (i == total - 1);
      e.stamped = e.last && any;
      q.push_back(e);
    end
    for (int i = 0; i < total; i++) begin
      bit acc = 1'b0;
      @(negedge clk);
      if (i == pre) begin
        ts_sec = sec;
        ts_ns  = ns;
      end else if (scramble_ts) begin
        ts_sec = ~sec;
        ts_ns  = ~ns;
      end
      while (stall_en && lfsr[5] && lfsr[9]) begin
        in_valid = 1'b0;
        @(negedge clk);
        void'(lfsr_bit());
      end
      in_valid     = 1'b1;
      in_data      = frame_byte(i, pre, mt, mv);
      in_last      = (i == total - 1);
      in_hdr_start = (i == pre);
      while (!acc) begin
        #(CLK_PERIOD/2 - 1);
        acc = in_ready;
        @(negedge clk);
      end
      in_valid = 1'b0;
      in_hdr_start = 1'b0;
      in_last = 1'b0;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (q.size() != 0) check("R1", q.size(), 0, "beats missing");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", {31'd0, out_valid}, 32'd0, "out_valid in reset");
    check("R12", {31'd0, out_stamped}, 32'd0, "out_stamped in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {31'd0, in_ready}, 32'd1, "in_ready after reset");
    check("R12", {31'd0, out_valid}, 32'd0, "out_valid after reset");

    cfg_type_mask  = 16'h000F;   // message types 0..3
    cfg_version    = 4'd2;
    cfg_ins_en     = 1'b1;
    cfg_sec_en     = 1'b0;
    cfg_ns_offset  = 6'd8;
    cfg_sec_offset = 6'd20;

    send_frame("R5", 14, 34, 4'd0, 4'd2, 32'h0000_0003, 32'h1234_5678, 0);
    drain();
    stall_en = 1'b1;
    cfg_sec_en = 1'b1;
    send_frame("R5", 14, 34, 4'd1, 4'd2, 32'h0000_00A5, 32'hF00D_BEEF, 0);
    send_frame("R6", 6, 30, 4'd2, 4'd2, 32'h0000_0C3E, 32'h2A00_0001, 0);
    send_frame("R3", 14, 34, 4'd8, 4'd2, 32'h1, 32'h1111_1111, 0);
    send_frame("R4", 14, 34, 4'd3, 4'd1, 32'h2, 32'h2222_2222, 0);
    drain();
    cfg_version = 4'd0;
    send_frame("R4", 4, 34, 4'd3, 4'd9, 32'h7, 32'h0BAD_CAFE, 0);
    drain();
    cfg_ins_en = 1'b0;
    send_frame("R6", 4, 34, 4'd0, 4'd2, 32'hF, 32'h3333_3333, 0);
    drain();
    cfg_ins_en = 1'b1;
    cfg_ns_offset = 6'd10;
    cfg_sec_offset = 6'd12;
    send_frame("R7", 2, 30, 4'd1, 4'd2, 32'h9, 32'h0765_4321, 0);
    drain();
    cfg_ns_offset = 6'd1;
    cfg_sec_offset = 6'd0;
    send_frame("R8", 3, 20, 4'd0, 4'd2, 32'h6, 32'h0102_0304, 0);
    drain();
    cfg_ns_offset = 6'd8;
    cfg_sec_offset = 6'd30;
    send_frame("R10", 5, 6, 4'd0, 4'd2, 32'h6, 32'h0102_0304, 0);
    send_frame("R10", 0, 12, 4'd0, 4'd2, 32'h1, 32'h3ABC_DEF0, 0);
    drain();
    cfg_ns_offset = 6'd63;
    cfg_sec_offset = 6'd40;
    send_frame("R2", 9, 67, 4'd2, 4'd2, 32'hB, 32'h0055_AA77, 0);
    drain();
    cfg_ns_offset = 6'd16;
    cfg_sec_offset = 6'd24;
    send_frame("R9", 3, 40, 4'd3, 4'd2, 32'h0000_0006, 32'h1357_9BDF, 1);
    send_frame("R11", 0, 28, 4'd3, 4'd2, 32'h4, 32'h2468_ACE0, 0);
    send_frame("R11", 0, 28, 4'd5, 4'd2, 32'h4, 32'h2468_ACE0, 0);
    drain();
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", {31'd0, out_stamped}, 32'd0, "stamp idle");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule